// File: doc/BRIEF.md
# HDLC Byte Boundary Recovery Counter

This block finds byte boundaries in a serial HDLC receive stream after zero-stuffing removal. It takes a strobe that marks each destuffed bit and a pulse that marks a detected FLAG. It gives back a one-cycle byte strobe for the adjacent 8-bit receive shift register, which a downstream FIFO or packet filter uses as its write enable. It also gives a level that tells the consumer the byte now being strobed is the first one after a FLAG.

A modulo-BYTE_BITS counter advances once per destuffed bit. A FLAG forces the counter to zero and sets a qualified-flag latch. That latch holds the counter at zero for one more destuffed bit, which lines the count up with the one-bit-delayed data feeding the receive register. As a result a FLAG byte never raises the strobe, and the first data byte completes on the ninth destuffed bit after the flag bit.

Top module: `hdlc_byte_align`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `byteStb` and `flagPreceded` are 0. After reset the counter is at zero, so the first strobe comes on the 8th destuffed bit.
- R2: The counter advances only in cycles where `bitValid` is 1. Cycles where `bitValid` is 0 leave it unchanged and never raise `byteStb`.
- R3: `byteStb` is a single-cycle pulse. It is high in the cycle after the destuffed bit that takes the counter from BYTE_BITS-1 back to 0.
- R4: A FLAG is `flagIn`=1 together with `bitValid`=1. It sets the counter to zero and gives no strobe, even when it lands on the counter's last position.
- R5: The destuffed bit right after a FLAG is not counted. The first strobe after a FLAG comes on the 9th destuffed bit after the flag bit.
- R6: Back-to-back FLAGs hold the counter at zero and raise no strobe. Only the bit after the last FLAG is held.
- R7: `flagPreceded` rises in the cycle after a FLAG. It stays high through the first strobe that follows and falls in the cycle after that strobe, unless a new FLAG arrives at the same time.
- R8: `flagIn` while `bitValid` is 0 has no effect on the counter or on `flagPreceded`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | One destuffed bit is present this cycle |
| flagIn | input | 1 | FLAG detected on the current bit (valid only with bitValid) |
| byteStb | output | 1 | One-cycle pulse: a full data byte is in the receive register |
| flagPreceded | output | 1 | The byte being strobed was directly preceded by a FLAG |

## Verification
The stimulus runs plain bytes from reset, with idle cycles mixed in, to show that only valid bits advance the count. It then sends a FLAG followed by a byte, to tell a held bit apart from a counted one: a miscount moves the strobe by one cycle. FLAGs arrive mid-byte, in a run of three, and exactly on the counter's last position, to separate realignment from plain wrap-around and to show that FLAGs never strobe. FLAG pulses without a valid bit are placed where a wrongful reset would move the next strobe or raise the indicator. A reset in the middle of a byte shows that reset also clears the hold.

// File: rtl/hdlc_byte_align_pkg.sv
package hdlc_byte_align_pkg;
  // Command from control to the bit counter datapath
  typedef struct packed {
    logic clear;    // force counter to zero
    logic advance;  // count one destuffed bit
  } cntCmd_t;
endpackage

// File: rtl/hdlc_byte_align_dp.sv
module hdlc_byte_align_dp
  import hdlc_byte_align_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cmd,
  output logic    atLast
);
  localparam int CW = (BYTE_BITS > 2) ? $clog2(BYTE_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_BITS - 1);

  logic [CW-1:0] bitCnt;

  assign atLast = (bitCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (cmd.clear) begin
      bitCnt <= '0;
    end else if (cmd.advance) begin
      bitCnt <= atLast ? '0 : bitCnt + CW'(1);
    end
  end
endmodule

// File: rtl/hdlc_byte_align_ctl.sv
module hdlc_byte_align_ctl
  import hdlc_byte_align_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitValid,
  input  logic    flagIn,
  input  logic    atLast,
  output cntCmd_t cmd,
  output logic    byteStb,
  output logic    flagPreceded
);
  logic flagHit;
  logic flagQ;   // qualified flag: holds the counter for one more bit

  assign flagHit     = bitValid && flagIn;
  assign cmd.clear   = flagHit || (bitValid && flagQ);
  assign cmd.advance = bitValid && !flagIn && !flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ        <= 1'b0;
      byteStb      <= 1'b0;
      flagPreceded <= 1'b0;
    end else begin
      if (flagHit)       flagQ <= 1'b1;
      else if (bitValid) flagQ <= 1'b0;

      byteStb <= cmd.advance && atLast;

      if (flagHit)      flagPreceded <= 1'b1;
      else if (byteStb) flagPreceded <= 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_byte_align.sv
module hdlc_byte_align
  import hdlc_byte_align_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic flagIn,
  output logic byteStb,
  output logic flagPreceded
);
  cntCmd_t cmd;
  logic    atLast;

  hdlc_byte_align_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .bitValid     (bitValid),
    .flagIn       (flagIn),
    .atLast       (atLast),
    .cmd          (cmd),
    .byteStb      (byteStb),
    .flagPreceded (flagPreceded)
  );

  hdlc_byte_align_dp #(.BYTE_BITS(BYTE_BITS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .atLast (atLast)
  );
endmodule

// File: rtl/hdlc_byte_align_chk.sv
module hdlc_byte_align_chk (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic flagIn,
  input logic byteStb,
  input logic flagPreceded
);
  // R1: outputs low in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> (!byteStb && !flagPreceded));

  // R2: idle cycle never produces a strobe
  p_idle_no_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> !byteStb);

  // R3: strobe lasts one cycle
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteStb |=> !byteStb);

  // R4: a FLAG bit never strobes
  p_flag_no_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && flagIn) |=> !byteStb);

  // R7: indicator set by FLAG
  p_prec_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && flagIn) |=> flagPreceded);

  // R7: indicator falls after the strobe it accompanies
  p_prec_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (byteStb && !(bitValid && flagIn)) |=> !flagPreceded);

  // R8: without a valid bit the indicator holds
  p_prec_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !byteStb) |=> $stable(flagPreceded));
endmodule

bind hdlc_byte_align hdlc_byte_align_chk u_chk (.*);

// File: tb/hdlc_byte_align_bench.sv
module hdlc_byte_align_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 23;

  // Segment fields: {req[3:0], repeat[3:0], valid, flag, expStb, expPrec}
  localparam logic [11:0] SEG [NSEG] = '{
    {4'd3, 4'd7, 4'b1000},  // R3 seven plain bits
    {4'd3, 4'd1, 4'b1010},  // R3 eighth bit strobes
    {4'd8, 4'd1, 4'b0100},  // R8 flag without valid ignored
    {4'd4, 4'd1, 4'b1101},  // R4 flag
    {4'd5, 4'd1, 4'b1001},  // R5 held bit
    {4'd2, 4'd1, 4'b0001},  // R2 idle
    {4'd5, 4'd7, 4'b1001},  // R5 counted bits
    {4'd7, 4'd1, 4'b1011},  // R7 strobe with indicator
    {4'd7, 4'd4, 4'b1000},  // R7 indicator cleared, count to 4
    {4'd6, 4'd3, 4'b1101},  // R6 three flags back to back
    {4'd6, 4'd1, 4'b1001},  // R6 single held bit
    {4'd6, 4'd7, 4'b1001},
    {4'd6, 4'd1, 4'b1011},
    {4'd3, 4'd1, 4'b0000},  // R3 pulse drops, R7 indicator cleared
    {4'd2, 4'd3, 4'b1000},
    {4'd8, 4'd1, 4'b0100},  // R8 flag without valid mid byte
    {4'd8, 4'd4, 4'b1000},
    {4'd8, 4'd1, 4'b1010},  // R8 strobe not shifted
    {4'd4, 4'd7, 4'b1000},  // count to last position
    {4'd4, 4'd1, 4'b1101},  // R4 flag at last position, no strobe
    {4'd5, 4'd1, 4'b1001},
    {4'd5, 4'd7, 4'b1001},
    {4'd5, 4'd1, 4'b1011}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0;
  logic flagIn = 1'b0;
  logic byteStb;
  logic flagPreceded;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_byte_align u_hdlc_byte_align (
    .clk          (clk),
    .rstN         (rstN),
    .bitValid     (bitValid),
    .flagIn       (flagIn),
    .byteStb      (byteStb),
    .flagPreceded (flagPreceded)
  );

  task automatic check(input int req, input logic expStb, input logic expPrec);
    nRun++;
    if (byteStb !== expStb || flagPreceded !== expPrec) begin
      nFail++;
      $display("FAIL R%0d t=%0t stb/prec actual %b%b expected %b%b",
               req, $time, byteStb, flagPreceded, expStb, expPrec);
    end
  endtask

  task automatic step(input logic v, input logic f);
    bitValid = v;
    flagIn   = f;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(1, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 1'b0, 1'b0);

    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < int'(SEG[s][7:4]); k++) begin
        step(SEG[s][3], SEG[s][2]);
        check(int'(SEG[s][11:8]), SEG[s][1], SEG[s][0]);
      end
    end

    // R1 mid-byte reset after a flag: clears indicator, count and hold
    step(1'b1, 1'b1);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
    check(7, 1'b0, 1'b1);
    rstN = 1'b0;
    step(1'b1, 1'b0);
    check(1, 1'b0, 1'b0);
    rstN = 1'b1;
    for (int k = 0; k < 7; k++) begin
      step(1'b1, 1'b0);
      check(1, 1'b0, 1'b0);
    end
    step(1'b1, 1'b0);
    check(1, 1'b1, 1'b0);
    step(1'b0, 1'b0);
    check(3, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule